// File: doc/BRIEF.md
# Two-Channel Staged 12-bit Converter Write Port

This block sits between a byte-wide host write bus and two 12-bit multiplying digital-to-analog converters. A 12-bit code does not fit in one bus transfer, so each channel takes it in two writes. The low byte goes first and is parked in a per-channel holding register. The converter input does not move at that point.

The second write carries the top four bits in the low nibble of the data byte. That write loads the full 12-bit code into the channel's output latch in a single clock edge, so the converter never sees a mix of old and new bits. A one-cycle update pulse marks each load.

The two channels occupy four consecutive bus offsets. Reads at these offsets belong to other functions and are not handled here.

Top module: `dac_wport`

## Requirements
- R1: After reset, both 12-bit outputs are zero, both update pulses are low and both holding registers are zero. A high-nibble write with no prior low-byte write therefore outputs {nibble, 8'h00}.
- R2: A write to a channel's low-byte offset stores the 8-bit data in that channel's holding register. It changes neither output and raises no update pulse.
- R3: A write to a channel's high offset loads {wr_data[3:0], holding register} into that channel's output in the cycle after the write edge. The channel's update pulse is high for exactly that one cycle.
- R4: Bits 7:4 of a high-offset write have no effect on the output.
- R5: Channel 0 decodes its low byte at offset 4 and its high nibble at offset 5. Channel 1 decodes its low byte at offset 6 and its high nibble at offset 7. A write to one channel leaves the other channel's output, pulse and holding register unchanged.
- R6: Writes to offsets 0 to 3 and 8 to 15 change no output and raise no pulse.
- R7: The holding register keeps its value across high-nibble writes. Repeated high writes reuse the last low byte.
- R8: With wr_en low, no offset or data value changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 8 | Write data byte |
| dac_code | output | 24 | Channel 1 code in [23:12], channel 0 code in [11:0] |
| dac_upd | output | 2 | One-cycle load pulse per channel, bit 0 for channel 0 |

## Verification
The bench sweeps every nibble against a spread of low bytes on both channels, and sets the ignored upper nibble to varying patterns.

- A design that forwards the low byte early fails the check right after the low-byte write.
- A design that swaps nibble positions, or keeps the upper bits, shows a wrong code.
- A design that clears the holding register on transfer breaks the repeated-high-write case.

A full sweep over all offsets, with the enable both on and off, exposes any loose address decode, because that decode would disturb the other channel or fire a stray pulse.

// File: rtl/dac_wport.sv
module dac_wport #(
  parameter int NCH    = 2,
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  parameter int BASE   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [NCH*CODE_W-1:0]   dac_code,
  output logic [NCH-1:0]          dac_upd
);
  localparam int HI_W = CODE_W - BYTE_W;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE + 2*i);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + 2*i + 1);

    logic [BYTE_W-1:0] hold;
    logic [CODE_W-1:0] code;
    logic              upd;
    logic              lo_hit, hi_hit;

    assign lo_hit = wr_en && (wr_addr == LO_A);
    assign hi_hit = wr_en && (wr_addr == HI_A);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold <= '0;
        code <= '0;
        upd  <= 1'b0;
      end else begin
        upd <= hi_hit;
        if (lo_hit) hold <= wr_data;
        if (hi_hit) code <= {wr_data[HI_W-1:0], hold};
      end
    end

    assign dac_code[i*CODE_W +: CODE_W] = code;
    assign dac_upd[i] = upd;
  end
endmodule

module dac_wport_chk #(
  parameter int NCH    = 2,
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  parameter int BASE   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [BYTE_W-1:0]     wr_data,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        dac_upd
);
  localparam int HI_W = CODE_W - BYTE_W;

  for (genvar i = 0; i < NCH; i++) begin : g_a
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE + 2*i);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + 2*i + 1);

    a_r2_low_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == LO_A) |=> ($stable(dac_code[i*CODE_W +: CODE_W]) && !dac_upd[i]));
    a_r3_pulse_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == HI_A) |=> dac_upd[i]);
    a_r5_no_pulse_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == HI_A) |=> !dac_upd[i]);
    a_r4_nibble_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == HI_A) |=>
        (dac_code[i*CODE_W+BYTE_W +: HI_W] == $past(wr_data[HI_W-1:0])));
    a_r6_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_upd[i] |-> $stable(dac_code[i*CODE_W +: CODE_W]));
  end
endmodule

bind dac_wport dac_wport_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (.*);

// File: tb/tb_dac_wport.sv
module tb_dac_wport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] dac_code;
  logic [1:0]  dac_upd;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  m_buf  [2];
  logic [11:0] m_code [2];
  logic [1:0]  m_upd;

  always #2 clk = ~clk;

  dac_wport dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .dac_code, .dac_upd);

  task automatic check(string req);
    for (int c = 0; c < 2; c++) begin
      n_chk++;
      if (dac_code[c*12 +: 12] !== m_code[c] || dac_upd[c] !== m_upd[c]) begin
        n_bad++;
        $display("FAIL %s ch%0d code=%h upd=%b expected code=%h upd=%b",
                 req, c, dac_code[c*12 +: 12], dac_upd[c], m_code[c], m_upd[c]);
      end
    end
  endtask

  task automatic wr(input logic en, input logic [3:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    m_upd = '0;
    if (en && a >= 4 && a <= 7) begin
      int c = (int'(a) - 4) / 2;
      if (a[0] == 1'b0) m_buf[c] = d;
      else begin
        m_code[c] = {d[3:0], m_buf[c]};
        m_upd[c] = 1'b1;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(req);
    m_upd = '0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_buf[c] = '0; m_code[c] = '0; end
    m_upd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state");
    wr(1, 4'd5, 8'h0A, "R1 zero holding register");
    wr(1, 4'd7, 8'h03, "R1 zero holding register ch1");

    for (int c = 0; c < 2; c++)
      for (int lo = 0; lo < 256; lo += 17)
        for (int hi = 0; hi < 16; hi++) begin
          wr(1, 4'(4 + 2*c), 8'(lo ^ hi), "R2 low write staged");
          wr(1, 4'(5 + 2*c), 8'(((hi * 5) << 4) | hi), "R3 R4 R5 high transfer");
        end

    wr(1, 4'd4, 8'hC3, "R2 stage");
    wr(1, 4'd5, 8'h01, "R7 first high");
    wr(1, 4'd5, 8'hF9, "R7 repeat high reuses low");
    wr(1, 4'd7, 8'h02, "R7 ch1 repeat high");

    for (int a = 0; a < 16; a++)
      for (int d = 0; d < 256; d += 51) begin
        wr(0, 4'(a), 8'(d), "R8 disabled write");
        wr(1, 4'(a), 8'(d), "R6 R5 address sweep");
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule